// File: doc/BRIEF.md
# Receive Frame FIFO with Word Readout

This block collects received Ethernet frames, delivered as a byte stream, into a word-wide buffer and hands them to a processor one 32-bit word per read strobe. Every buffered frame is laid out as a fixed marker word, then a packed length/status word, then its payload packed four bytes per word. Software polls a frame counter, reads the marker to confirm alignment, reads the header to learn the byte count, and then reads the payload.

The byte input is a valid/ready stream. The source holds `in_valid` and its data steady until it sees `in_ready` high at a rising edge. `in_ready` falls for two cycles after each end-of-frame byte while the header and marker are written, and for the one cycle of a flush. A frame that cannot fit in the free space is discarded whole. A flush empties the buffer in two cycles. A receive-enable input decides at each start-of-frame byte whether that frame is kept.

Top module: `rxfifo_framer`

## Requirements
- R1: The first word read for each buffered frame is the constant 0x0143414D.
- R2: The second word holds the frame length in bytes in bits 15:0 and a status in bits 31:16. Status bit 4 is the CRC error flag, status bits 6:5 are the two length error flags, all sampled with the end-of-frame byte, and the other status bits are zero.
- R3: The payload follows as ceil(length/4) words. Byte n of the frame sits in word n/4 at bits 8*(n%4)+7 down to 8*(n%4), and unused upper bytes of the last word read as zero.
- R4: `frame_count` equals the number of complete frames buffered. It rises on the second clock edge after the edge that accepts an end-of-frame byte. It falls at the edge that reads the last payload word of a frame.
- R5: A one-cycle `count_clear` sets `frame_count` to zero at the next edge.
- R6: A one-cycle `flush_req` makes `flush_busy` read 1 for exactly the next cycle. At the following edge the buffer empties, `frame_count` becomes 0 and `overflow` becomes 0, and `flush_busy` then reads 0.
- R7: A frame whose start byte arrives while `rx_enable` is 0 is accepted from the stream and discarded. It is not counted and does not set `overflow`.
- R8: A frame needing more words than are free is discarded whole and sets `overflow`, which stays set until a flush. Frames already buffered are unaffected, and a frame that exactly fills the buffer is kept.
- R9: While `frame_count` is 0, `rd_data` is 0 and `rd_en` does not move the read position.
- R10: `in_ready` is 0 for the two cycles after an end-of-frame byte is accepted and during `flush_busy`. Bytes arriving outside a frame without a start flag are accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Keep frames starting while high |
| flush_req | input | 1 | Pulse to empty the buffer |
| flush_busy | output | 1 | High while a flush is pending |
| count_clear | input | 1 | Pulse to zero the frame counter |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_crc_err | input | 1 | CRC error flag, sampled with the end byte |
| in_len_err | input | 2 | Length error flags, sampled with the end byte |
| rd_en | input | 1 | Read strobe, consumes the current word |
| rd_data | output | 32 | Current word at the read position |
| frame_count | output | $clog2(DEPTH)+1 | Complete frames buffered |
| overflow | output | 1 | Sticky: a frame was dropped for lack of space |

## Verification
The bench builds the block with DEPTH set to 16 words. At that size a 41-byte frame queued behind an 8-byte frame runs out of space, which exercises the whole-frame drop. A 56-byte frame fills the buffer exactly, which exercises the exact-fit boundary. The table of frames also wraps the word pointers several times, so the wraparound arithmetic of the free-space check is covered with short runs.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [31:0] RXF_MARKER = 32'h0143414D;

  typedef enum logic [2:0] {
    W_IDLE,
    W_BODY,
    W_DROP,
    W_HDR,
    W_MARK
  } wr_state_e;

  function automatic logic [15:0] rxf_status(input logic crc, input logic [1:0] lerr);
    return {9'd0, lerr, crc, 4'd0};
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_q
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_q = mem[rd_addr];
endmodule

// File: rtl/rxf_writer.sv
module rxf_writer
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hold,
  input  logic          enable,
  input  logic [PW-1:0] rd_ptr,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_crc_err,
  input  logic [1:0]    in_len_err,
  output logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          commit,
  output logic          overflow
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  wr_state_e     st;
  logic [PW-1:0] cptr, wc;
  logic [15:0]   len_q, stat_q;
  logic [31:0]   pack_q;

  logic          acc, body, need_wr, room;
  logic [1:0]    lane;
  logic [PW-1:0] base, used_c, used_w, slack;
  logic [31:0]   word;

  assign in_ready = !hold && (st != W_HDR) && (st != W_MARK);
  assign acc      = in_valid && in_ready;
  assign body     = (st == W_BODY);
  assign base     = body ? wc : cptr + PW'(2);
  assign lane     = body ? len_q[1:0] : 2'd0;
  assign need_wr  = (lane == 2'd3) || in_eof;
  assign used_c   = cptr - rd_ptr;
  assign used_w   = wc - rd_ptr;
  assign slack    = need_wr ? DEPTH_P - PW'(3) : DEPTH_P - PW'(2);
  assign room     = body ? (!need_wr || (used_w < DEPTH_P)) : (used_c <= slack);
  assign commit   = (st == W_MARK);

  always_comb begin
    word = body ? pack_q : 32'd0;
    word[{lane, 3'b000} +: 8] = in_data;
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = base[AW-1:0];
    wr_data = word;
    if (st == W_HDR) begin
      wr_en   = 1'b1;
      wr_addr = AW'(cptr + PW'(1));
      wr_data = {stat_q, len_q};
    end else if (st == W_MARK) begin
      wr_en   = 1'b1;
      wr_addr = cptr[AW-1:0];
      wr_data = RXF_MARKER;
    end else if (acc && need_wr && room &&
                 (body || (st == W_IDLE && in_sof && enable))) begin
      wr_en = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st       <= W_IDLE;
      cptr     <= '0;
      wc       <= '0;
      len_q    <= '0;
      stat_q   <= '0;
      pack_q   <= '0;
      overflow <= 1'b0;
    end else begin
      unique case (st)
        W_IDLE, W_BODY: begin
          if (acc && (body || in_sof)) begin
            if (!body && !enable) begin
              st <= in_eof ? W_IDLE : W_DROP;
            end else if (!room) begin
              overflow <= 1'b1;
              st       <= in_eof ? W_IDLE : W_DROP;
            end else begin
              len_q <= body ? len_q + 16'd1 : 16'd1;
              if (need_wr) begin
                wc     <= base + PW'(1);
                pack_q <= '0;
              end else begin
                wc     <= base;
                pack_q <= word;
              end
              if (in_eof) begin
                stat_q <= rxf_status(in_crc_err, in_len_err);
                st     <= W_HDR;
              end else begin
                st <= W_BODY;
              end
            end
          end
        end
        W_DROP:  if (acc && in_eof) st <= W_IDLE;
        W_HDR:   st <= W_MARK;
        W_MARK: begin
          cptr <= wc;
          st   <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxf_reader.sv
module rxf_reader #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int CW = PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          count_clear,
  input  logic          commit,
  input  logic          rd_en,
  input  logic [31:0]   mem_q,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rd_ptr,
  output logic [31:0]   rd_data,
  output logic [CW-1:0] frame_count
);
  logic [1:0]  phase;
  logic [15:0] remain;
  logic        pending, hit, done;

  assign pending = (frame_count != '0);
  assign hit     = rd_en && pending;
  assign done    = hit && (phase == 2'd2) && (remain <= 16'd1);
  assign rd_data = pending ? mem_q : 32'd0;
  assign rd_addr = rd_ptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rd_ptr <= '0;
      phase  <= 2'd0;
      remain <= '0;
    end else if (hit) begin
      rd_ptr <= rd_ptr + PW'(1);
      case (phase)
        2'd0: phase <= 2'd1;
        2'd1: begin
          remain <= {2'b00, mem_q[15:2]} + {15'd0, |mem_q[1:0]};
          phase  <= 2'd2;
        end
        default: begin
          remain <= remain - 16'd1;
          if (remain <= 16'd1) phase <= 2'd0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr || count_clear) frame_count <= '0;
    else if (commit && !done)         frame_count <= frame_count + CW'(1);
    else if (done && !commit)         frame_count <= frame_count - CW'(1);
  end
endmodule

// File: rtl/rxfifo_framer.sv
module rxfifo_framer #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int CW = PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enable,
  input  logic          flush_req,
  output logic          flush_busy,
  input  logic          count_clear,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_crc_err,
  input  logic [1:0]    in_len_err,
  input  logic          rd_en,
  output logic [31:0]   rd_data,
  output logic [CW-1:0] frame_count,
  output logic          overflow
);
  logic          wr_en, commit;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0]   wr_data, mem_q;
  logic [PW-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n)          flush_busy <= 1'b0;
    else if (flush_busy) flush_busy <= 1'b0;
    else if (flush_req)  flush_busy <= 1'b1;
  end

  rxf_writer #(.DEPTH(DEPTH)) u_writer (
    .clk(clk), .rst_n(rst_n), .clr(flush_busy), .hold(flush_busy),
    .enable(rx_enable), .rd_ptr(rd_ptr),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_crc_err(in_crc_err), .in_len_err(in_len_err), .in_ready(in_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .overflow(overflow)
  );

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_q(mem_q)
  );

  rxf_reader #(.DEPTH(DEPTH)) u_reader (
    .clk(clk), .rst_n(rst_n), .clr(flush_busy), .count_clear(count_clear),
    .commit(commit), .rd_en(rd_en), .mem_q(mem_q), .rd_addr(rd_addr),
    .rd_ptr(rd_ptr), .rd_data(rd_data), .frame_count(frame_count)
  );
endmodule

// File: rtl/rxfifo_framer_chk.sv
module rxfifo_framer_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush_busy,
  input logic          in_ready,
  input logic          count_clear,
  input logic [CW-1:0] frame_count,
  input logic          overflow
);
  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> !flush_busy); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> (frame_count == '0 && !overflow)); // R6

  AST_FLUSH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !in_ready); // R10

  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    count_clear |=> (frame_count == '0)); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_clear && !flush_busy) |=>
      (frame_count == $past(frame_count) ||
       frame_count == $past(frame_count) + CW'(1) ||
       frame_count == $past(frame_count) - CW'(1))); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush_busy) |=> overflow); // R8
endmodule

bind rxfifo_framer rxfifo_framer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_busy(flush_busy), .in_ready(in_ready),
  .count_clear(count_clear), .frame_count(frame_count), .overflow(overflow)
);

// File: tb/rxfifo_framer_test.sv
module rxfifo_framer_test;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [31:0] MARK = 32'h0143414D;
  localparam int NV = 6;
  // {length, crc, len_err, seed}
  localparam logic [26:0] VEC [NV] = '{
    {16'd1,  1'b0, 2'b00, 8'h10},
    {16'd4,  1'b1, 2'b00, 8'h20},
    {16'd5,  1'b0, 2'b01, 8'h30},
    {16'd8,  1'b0, 2'b10, 8'h40},
    {16'd13, 1'b1, 2'b11, 8'h50},
    {16'd3,  1'b0, 2'b00, 8'hF0}
  };

  logic clk = 1'b0;
  logic rst_n, rx_enable, flush_req, flush_busy, count_clear;
  logic in_valid, in_ready, in_sof, in_eof, in_crc_err, rd_en, overflow;
  logic [7:0] in_data;
  logic [1:0] in_len_err;
  logic [31:0] rd_data;
  logic [CW-1:0] frame_count;
  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rxfifo_framer #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .flush_req(flush_req),
    .flush_busy(flush_busy), .count_clear(count_clear), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_crc_err(in_crc_err), .in_len_err(in_len_err), .rd_en(rd_en),
    .rd_data(rd_data), .frame_count(frame_count), .overflow(overflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int len, input logic [7:0] seed, input int k);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++)
      if (4 * k + b < len) w[8*b +: 8] = seed + 8'(4 * k + b);
    return w;
  endfunction

  task automatic send_frame(input int len, input logic crc, input logic [1:0] le, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = seed + 8'(i);
      in_sof = (i == 0); in_eof = (i == len - 1);
      in_crc_err = crc; in_len_err = le;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic read_word(output logic [31:0] w);
    w = rd_data;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic read_frame(input int len, input logic crc, input logic [1:0] le, input logic [7:0] seed);
    logic [31:0] w;
    read_word(w); check("R1 marker", w, MARK);
    read_word(w); check("R2 header", w, {9'd0, le, crc, 4'd0, 16'(len)});
    for (int k = 0; k < (len + 3) / 4; k++) begin
      read_word(w); check("R3 payload", w, exp_word(len, seed, k));
    end
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    rst_n = 1'b0; rx_enable = 1'b1; flush_req = 1'b0; count_clear = 1'b0;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
    in_crc_err = 1'b0; in_len_err = '0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R4 reset count", 32'(frame_count), 0);
    check("R8 reset overflow", 32'(overflow), 0);
    check("R6 reset busy", 32'(flush_busy), 0);
    check("R10 reset ready", 32'(in_ready), 1);
    check("R9 reset data", rd_data, 0);

    for (int v = 0; v < NV; v++) begin
      send_frame(int'(VEC[v][26:11]), VEC[v][10], VEC[v][9:8], VEC[v][7:0]);
      check("R10 stall after end", 32'(in_ready), 0);
      @(negedge clk);
      check("R10 stall second", 32'(in_ready), 0);
      check("R4 not yet counted", 32'(frame_count), 0);
      @(negedge clk);
      check("R4 counted", 32'(frame_count), 1);
      read_frame(int'(VEC[v][26:11]), VEC[v][10], VEC[v][9:8], VEC[v][7:0]);
      check("R4 count after read", 32'(frame_count), 0);
    end

    // R9: empty read does not move the read position
    read_word(w); check("R9 empty data", w, 0);
    read_word(w); check("R9 empty data again", w, 0);
    send_frame(6, 1'b0, 2'b00, 8'h60); settle();
    read_frame(6, 1'b0, 2'b00, 8'h60);

    // R7: disabled reception drops frame
    rx_enable = 1'b0;
    send_frame(5, 1'b1, 2'b00, 8'h11); settle();
    check("R7 not counted", 32'(frame_count), 0);
    check("R7 no overflow", 32'(overflow), 0);
    check("R7 data zero", rd_data, 0);
    rx_enable = 1'b1;
    send_frame(2, 1'b0, 2'b00, 8'h70); settle();
    check("R7 next frame counted", 32'(frame_count), 1);
    read_frame(2, 1'b0, 2'b00, 8'h70);

    // R10: stray bytes without start flag are discarded
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_data = 8'hEE; in_sof = 1'b0; in_eof = (i == 2);
      @(negedge clk);
    end
    in_valid = 1'b0; in_eof = 1'b0;
    settle();
    check("R10 stray ignored", 32'(frame_count), 0);
    send_frame(7, 1'b0, 2'b01, 8'h77); settle();
    read_frame(7, 1'b0, 2'b01, 8'h77);

    // R5: counter clear
    send_frame(4, 1'b0, 2'b00, 8'h01); settle();
    send_frame(4, 1'b0, 2'b00, 8'h02); settle();
    check("R4 two frames", 32'(frame_count), 2);
    count_clear = 1'b1; @(negedge clk); count_clear = 1'b0;
    check("R5 cleared", 32'(frame_count), 0);
    check("R5 data zero after clear", rd_data, 0);

    // R6: flush
    flush_req = 1'b1; @(negedge clk); flush_req = 1'b0;
    check("R6 busy", 32'(flush_busy), 1);
    check("R10 no ready in flush", 32'(in_ready), 0);
    @(negedge clk);
    check("R6 busy self clears", 32'(flush_busy), 0);
    check("R6 count zero", 32'(frame_count), 0);

    // R8: exact fit kept
    send_frame(56, 1'b0, 2'b00, 8'h00); settle();
    check("R8 exact fit counted", 32'(frame_count), 1);
    check("R8 exact fit no overflow", 32'(overflow), 0);
    read_frame(56, 1'b0, 2'b00, 8'h00);

    // R8: frame too big dropped whole
    send_frame(8, 1'b0, 2'b00, 8'h80); settle();
    send_frame(41, 1'b0, 2'b00, 8'h90); settle();
    check("R8 overflow set", 32'(overflow), 1);
    check("R8 dropped not counted", 32'(frame_count), 1);
    read_frame(8, 1'b0, 2'b00, 8'h80);
    send_frame(3, 1'b1, 2'b10, 8'hA0); settle();
    check("R8 overflow sticky", 32'(overflow), 1);
    read_frame(3, 1'b1, 2'b10, 8'hA0);
    flush_req = 1'b1; @(negedge clk); flush_req = 1'b0; @(negedge clk);
    check("R6 flush clears overflow", 32'(overflow), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule